// File: doc/BRIEF.md
# Line-Tagged Receive Queue

This block is the shared receive queue of a four-line serial controller. Every character that arrives on any line is stored together with a small tag naming its line. A single consumer drains the queue by strobing a receive-buffer read. The read returns one packed word holding a valid flag, the line tag and the character. Storage is a circular buffer whose two pointers wrap to zero at the end.

One line is designated as the pointing-device line. Such a device can flood the queue with position reports. To stop it from crowding out the other lines, a push from that line is thrown away without notice while the queue holds more than half its capacity. Pushes from every other line are always taken. If a push wraps the write pointer onto the read pointer, the queue has overrun. A sticky overrun flag records this until reset.

The consumer side also has a non-empty status and a receive-done status. A receive-buffer read clears receive-done, which acknowledges the pending receive event.

Top module: `rx_line_queue`

## Requirements
- R1: After reset `not_empty`, `rx_done`, `overrun` and `rbuf_word` are all zero.
- R2: A pop of a non-empty queue sets `rbuf_word` one clock later to {bit 15 = 1, bits 14:10 = 0, bits 9:8 = line, bits 7:0 = character}, in first-in first-out order. `rbuf_word` holds its value until the next pop.
- R3: A pop of an empty queue sets `rbuf_word` to all zeros one clock later and leaves the read pointer where it is. The next pushed entry is the next one returned.
- R4: Order and tags are kept when the pointers wrap past the end of storage, over many passes.
- R5: A push whose line equals `MOUSE_LINE` is dropped when occupancy (write pointer minus read pointer, modulo depth) is greater than DEPTH/2. It is accepted when occupancy is DEPTH/2 or less.
- R6: A push from any other line is accepted at every occupancy.
- R7: `not_empty` is 1 exactly when occupancy is non-zero after the last clock edge.
- R8: `rx_done` becomes 1 at the clock edge after any edge at which the queue was non-empty and no pop was requested. A pop request clears it at its own edge.
- R9: `overrun` is set when an accepted push leaves the write pointer equal to the read pointer. It stays set until reset.
- R10: A push and a pop in the same cycle both take effect. The pop returns the oldest entry from before that edge, and the drop decision uses the occupancy from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request for this cycle |
| push_line | input | LINE_W (2) | Line number of the pushed character |
| push_char | input | CHAR_W (8) | Pushed character |
| pop | input | 1 | Receive-buffer read strobe |
| rbuf_word | output | WORD_W (16) | Packed valid/line/character word of the last pop |
| not_empty | output | 1 | Queue holds at least one entry |
| rx_done | output | 1 | Receive-done status, cleared by a pop |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the queue with ADDR_W = 3 (eight entries) and MOUSE_LINE = 1. With these values the half-full threshold of four, a complete wrap and the overrun point are all only a few pushes away. It sweeps every fill level from zero to six against every line, so the drop boundary is tested on both sides for the designated line and for the others. It also runs many wrap passes and same-cycle push/pop traffic. A cycle-level model in the bench checks every output after every edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W    = 8;
    localparam int LINE_W    = 2;
    localparam int WORD_W    = 16;
    localparam int LINE_LSB  = 8;
    localparam int VALID_BIT = WORD_W - 1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic valid, input rxq_entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[VALID_BIT] = valid;
        w[LINE_LSB +: LINE_W] = e.line;
        w[CHAR_W-1:0] = e.ch;
        return w;
    endfunction
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
    import rxq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MOUSE_LINE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_go,
    output logic              nonempty,
    output logic              overrun
);
    localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [LINE_W-1:0] MLINE = LINE_W'(MOUSE_LINE);

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic              ovr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [ADDR_W-1:0] occ_d;
    logic drop_d, accept_d, pop_go_d;

    always_comb begin
        occ_d    = st_q.wr - st_q.rd;
        drop_d   = push_valid && (push_line == MLINE) && (occ_d > HALF);
        accept_d = push_valid && !drop_d;
        pop_go_d = pop && (occ_d != '0);
        st_d     = st_q;
        st_d.wr  = st_q.wr + ADDR_W'(accept_d);
        st_d.rd  = st_q.rd + ADDR_W'(pop_go_d);
        if (accept_d && (st_d.wr == st_d.rd))
            st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en    = accept_d;
    assign wr_addr  = st_q.wr;
    assign rd_addr  = st_q.rd;
    assign rd_go    = pop_go_d;
    assign nonempty = (occ_d != '0);
    assign overrun  = st_q.ovr;

    a_r5_mouse_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_line == MLINE && (st_q.wr - st_q.rd) > HALF) |=> $stable(st_q.wr));
    a_r6_other_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_line != MLINE) |=> (st_q.wr == $past(st_q.wr) + ADDR_W'(1)));
    a_r3_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.wr == st_q.rd) |=> $stable(st_q.rd));
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  rxq_entry_t        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              pop,
    input  logic              rd_go,
    output logic [WORD_W-1:0] rbuf_word
);
    localparam int DEPTH = 1 << ADDR_W;

    rxq_entry_t mem [DEPTH];
    logic [WORD_W-1:0] rbuf_d, rbuf_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rbuf_d = rbuf_q;
        if (pop)
            rbuf_d = rd_go ? pack_word(1'b1, mem[rd_addr]) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rbuf_q <= '0;
        else        rbuf_q <= rbuf_d;
    end

    assign rbuf_word = rbuf_q;

    a_r2_hold_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(rbuf_q));
endmodule

// File: rtl/rx_line_queue.sv
module rx_line_queue
    import rxq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MOUSE_LINE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [LINE_W-1:0] push_line,
    input  logic [CHAR_W-1:0] push_char,
    input  logic              pop,
    output logic [WORD_W-1:0] rbuf_word,
    output logic              not_empty,
    output logic              rx_done,
    output logic              overrun
);
    logic              wr_en, rd_go, nonempty_now;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    rxq_entry_t        wr_data;
    logic              done_d, done_q;

    assign wr_data = '{line: push_line, ch: push_char};

    rxq_ptrs #(.ADDR_W(ADDR_W), .MOUSE_LINE(MOUSE_LINE)) i_ptrs (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_line(push_line),
        .pop(pop), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .rd_go(rd_go), .nonempty(nonempty_now), .overrun(overrun)
    );

    rxq_store #(.ADDR_W(ADDR_W)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .pop(pop), .rd_go(rd_go), .rbuf_word(rbuf_word)
    );

    always_comb done_d = !pop && nonempty_now;

    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign rx_done   = done_q;
    assign not_empty = nonempty_now;

    a_r8_pop_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !rx_done);
    a_r2_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && not_empty) |=> rbuf_word[VALID_BIT]);
    a_r3_empty_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !not_empty) |=> (rbuf_word == '0));
endmodule

// File: tb/test_rx_line_queue.sv
module test_rx_line_queue;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [1:0] push_line = '0;
    logic [7:0] push_char = '0;
    logic pop = 1'b0;
    logic [15:0] rbuf_word;
    logic not_empty, rx_done, overrun;

    always #10 clk = ~clk;

    rx_line_queue #(.ADDR_W(3), .MOUSE_LINE(1)) i_rx_line_queue (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_line(push_line),
        .push_char(push_char), .pop(pop), .rbuf_word(rbuf_word),
        .not_empty(not_empty), .rx_done(rx_done), .overrun(overrun)
    );

    int n_tests = 0;
    int n_fail = 0;
    logic [9:0] mq [8];
    int mwr = 0, mrd = 0, mocc = 0;
    logic movr = 1'b0, mdone = 1'b0;
    logic [15:0] mrbuf = '0;
    int valid_pops = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic cycle(input logic dp, input logic [1:0] l, input logic [7:0] c,
                         input logic dq, input string req);
        int pre;
        logic acc;
        @(negedge clk);
        push_valid = dp; push_line = l; push_char = c; pop = dq;
        pre = mocc;
        acc = dp && !(l == 2'd1 && pre > 4);
        mdone = !dq && (pre != 0);
        if (dq) begin
            if (pre != 0) begin
                mrbuf = {1'b1, 5'b0, mq[mrd]};
                mrd = (mrd + 1) % 8;
                valid_pops++;
            end else mrbuf = '0;
        end
        if (acc) begin
            mq[mwr] = {l, c};
            mwr = (mwr + 1) % 8;
        end
        mocc = (mwr - mrd + 8) % 8;
        if (acc && mwr == mrd) movr = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; pop = 1'b0;
        check(req, rbuf_word, mrbuf);
        check("R7", not_empty, mocc != 0);
        check("R8", rx_done, mdone);
        check("R9", overrun, movr);
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 8 && mocc != 0; k++) cycle(1'b0, 2'd0, 8'd0, 1'b1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", rbuf_word, 0);
        check("R1", not_empty, 0);
        check("R1", rx_done, 0);
        check("R1", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rbuf_word, not_empty, rx_done, overrun}, 0);

        // R3: empty reads, then one push is the next entry returned
        cycle(1'b0, 2'd0, 8'd0, 1'b1, "R3");
        cycle(1'b0, 2'd0, 8'd0, 1'b1, "R3");
        cycle(1'b1, 2'd3, 8'h41, 1'b0, "R3");
        cycle(1'b0, 2'd0, 8'd0, 1'b0, "R3");
        cycle(1'b0, 2'd0, 8'd0, 1'b1, "R3");
        check("R3", rbuf_word, 16'h8341);

        // R5/R6: every fill level against every line
        for (int n = 0; n <= 6; n++) begin
            for (int l = 0; l < 4; l++) begin
                for (int k = 0; k < n; k++) cycle(1'b1, 2'd0, 8'(n * 16 + k), 1'b0, "R2");
                cycle(1'b1, 2'(l), 8'hA0 + 8'(l), 1'b0, (l == 1) ? "R5" : "R6");
                cycle(1'b0, 2'd0, 8'd0, 1'b0, "R8");
                valid_pops = 0;
                drain((l == 1) ? "R5" : "R6");
                check((l == 1) ? "R5" : "R6", valid_pops,
                      n + (((l != 1) || (n <= 4)) ? 1 : 0));
            end
        end

        // R4: many passes across the wrap point
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < 3; k++) cycle(1'b1, 2'((r + k) % 4), 8'(r * 3 + k), 1'b0, "R4");
            for (int k = 0; k < 3; k++) cycle(1'b0, 2'd0, 8'd0, 1'b1, "R4");
        end

        // R10: simultaneous push and pop, including the mouse line near threshold
        for (int k = 0; k < 5; k++) cycle(1'b1, 2'd2, 8'(k), 1'b0, "R10");
        for (int k = 0; k < 24; k++) cycle(1'b1, 2'(k % 4), 8'h60 + 8'(k), 1'b1, "R10");
        cycle(1'b1, 2'd1, 8'h77, 1'b0, "R10");
        cycle(1'b1, 2'd1, 8'h78, 1'b1, "R10");
        drain("R10");
        cycle(1'b1, 2'd1, 8'h79, 1'b1, "R10");
        drain("R10");

        // R9: eight pushes from empty wrap onto the read pointer
        for (int k = 0; k < 8; k++) cycle(1'b1, 2'd0, 8'hC0 + 8'(k), 1'b0, "R9");
        check("R9", overrun, 1);
        for (int k = 0; k < 3; k++) cycle(1'b0, 2'd0, 8'd0, 1'b1, "R9");
        cycle(1'b1, 2'd2, 8'h11, 1'b0, "R9");
        cycle(1'b0, 2'd0, 8'd0, 1'b1, "R9");
        check("R9", overrun, 1);

        summary();
    end
endmodule